// File: doc/BRIEF.md
# Serial Min-Sum Check Node Lane

This block is one lane of a layered low-density parity-check decoder. For each check node it takes the a-posteriori (APP) values of a layer one block position per cycle. Each value comes with a position tag. The lane subtracts the old check-to-variable message and keeps the resulting variable-to-check value in a slot picked by the tag. Meanwhile it tracks the smallest and second-smallest magnitudes, where the smallest one occurred, and the parity of all signs. The old message is not stored in full: it is rebuilt from a compact record (two scaled minima and an index) plus one sign bit for each position.

When the layer is closed, the tracked result is latched into a compact record. This frees the tracking logic for the next layer. The updated APP value and the new sign for each position are then read out one position per request. Because storage is addressed by position and not by arrival order, the caller may leave idle cycles between entries. This lets a split layer be scheduled around a dependency.

Top module: `nms_check_unit`

## Requirements
- R1: The old message for position p is rebuilt from `old_rec`. Its magnitude is bits [9:5] when p equals the index in bits [4:0], and bits [14:10] otherwise. It is negative when `old_sign` is 1. The variable-to-check value E = APP − old message is clamped to the range −128..127 and stored in slot p.
- R2: The magnitude of E is clipped to 31. Over one layer, the lane keeps the smallest magnitude, the second smallest, and the position of the smallest. On a tie, the entry that arrived first keeps the smallest slot, and the later one becomes the second smallest.
- R3: `new_rec` packs the scaled smallest magnitude in [14:10], the scaled second smallest in [9:5], and the index in [4:0]. Scaling a magnitude m gives (m>>1)+(m>>2).
- R4: For position p, the new message has magnitude scaled(second smallest) when p is the index, and scaled(smallest) otherwise. Its sign is negative when the XOR of the signs of all E values in the layer, excluding p's own, is 1. `out_sign` reports this sign, where 1 means negative.
- R5: One cycle after `out_req`, `out_valid` is 1 and `out_app` holds E[p] + new message, clamped to −128..127.
- R6: A cycle with `in_valid` low changes neither the tracking nor any stored E, whatever the other gather inputs are.
- R7: `in_start` with a valid entry discards the earlier tracking. `in_close` latches the result, including an entry given in the same cycle, and `rec_valid` is high from the next cycle. The latched record does not change while the next layer is gathered.
- R8: After reset, `out_valid`, `rec_valid`, `out_app`, `out_sign` and `new_rec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Gather entry present |
| in_start | input | 1 | First entry of a layer |
| in_close | input | 1 | Latch the layer result |
| in_pos | input | 5 | Block position of the entry |
| in_app | input | 8 | APP value, two's complement |
| old_rec | input | 15 | Compact record from the previous pass |
| old_sign | input | 1 | Old message sign at this position |
| out_req | input | 1 | Read-out request |
| out_pos | input | 5 | Position to read out |
| out_valid | output | 1 | Read-out result present |
| out_app | output | 8 | Updated APP value |
| out_sign | output | 1 | New message sign at that position |
| new_rec | output | 15 | New compact record |
| rec_valid | output | 1 | A record has been latched |

## Verification
The basic pattern has mixed signs and a zero record. It shows whether sign parity and minimum tracking work on their own. A pattern with a non-zero record and mixed old signs separates the indexed rebuild from the non-indexed one. Values near full scale test both clamps. Equal magnitudes show tie ordering, and idle cycles filled with random data test that gaps are ignored. A full 22-entry row reaches the last slot. A two-layer sequence checks that the record is held while the next layer is gathered and that tracking restarts for the new layer.

// File: rtl/nms_check_unit.sv
module nms_check_unit #(
  parameter int APP_W   = 8,
  parameter int EXT_W   = 6,
  parameter int ROW_MAX = 22
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       in_valid,
  input  logic                                       in_start,
  input  logic                                       in_close,
  input  logic [$clog2(ROW_MAX)-1:0]                 in_pos,
  input  logic [APP_W-1:0]                           in_app,
  input  logic [2*(EXT_W-1)+$clog2(ROW_MAX)-1:0]     old_rec,
  input  logic                                       old_sign,
  input  logic                                       out_req,
  input  logic [$clog2(ROW_MAX)-1:0]                 out_pos,
  output logic                                       out_valid,
  output logic [APP_W-1:0]                           out_app,
  output logic                                       out_sign,
  output logic [2*(EXT_W-1)+$clog2(ROW_MAX)-1:0]     new_rec,
  output logic                                       rec_valid
);
  localparam int PW = $clog2(ROW_MAX);
  localparam int MW = EXT_W - 1;
  localparam int RW = 2 * MW + PW;
  localparam int XW = APP_W + 2;
  localparam logic [MW-1:0] MAG_TOP = '1;

  function automatic logic [APP_W-1:0] sat_app(input logic [XW-1:0] v);
    if (v[XW-1] && !(&v[XW-2:APP_W-1]))      return {1'b1, {(APP_W-1){1'b0}}};
    else if (!v[XW-1] && (|v[XW-2:APP_W-1])) return {1'b0, {(APP_W-1){1'b1}}};
    else                                     return v[APP_W-1:0];
  endfunction

  function automatic logic [MW-1:0] scl(input logic [MW-1:0] m);
    return (m >> 1) + (m >> 2);
  endfunction

  // rebuild of the old message and forming E
  logic [PW-1:0]    oidx;
  logic [MW-1:0]    omag;
  logic [XW-1:0]    app_x, mag_x, diff;
  logic [APP_W-1:0] e_in, e_abs;
  logic [MW-1:0]    e_mag;

  assign oidx  = old_rec[PW-1:0];
  assign omag  = (in_pos == oidx) ? old_rec[PW +: MW] : old_rec[RW-1 -: MW];
  assign app_x = {{2{in_app[APP_W-1]}}, in_app};
  assign mag_x = {{(XW-MW){1'b0}}, omag};
  assign diff  = old_sign ? app_x + mag_x : app_x - mag_x;
  assign e_in  = sat_app(diff);
  assign e_abs = e_in[APP_W-1] ? (~e_in + 1'b1) : e_in;
  assign e_mag = (e_abs > {{(APP_W-MW){1'b0}}, MAG_TOP}) ? MAG_TOP : e_abs[MW-1:0];

  // running minimum and sign tracking
  logic [MW-1:0] trk_m1, trk_m2, b_m1, b_m2, u_m1, u_m2;
  logic [PW-1:0] trk_idx, b_idx, u_idx;
  logic          trk_sgn, b_sgn, u_sgn;

  always_comb begin
    b_m1  = in_start ? MAG_TOP : trk_m1;
    b_m2  = in_start ? MAG_TOP : trk_m2;
    b_idx = in_start ? '0      : trk_idx;
    b_sgn = in_start ? 1'b0    : trk_sgn;
    u_m1  = b_m1;
    u_m2  = b_m2;
    u_idx = b_idx;
    u_sgn = b_sgn ^ e_in[APP_W-1];
    if (e_mag < b_m1) begin
      u_m2  = b_m1;
      u_m1  = e_mag;
      u_idx = in_pos;
    end else if (e_mag < b_m2) begin
      u_m2  = e_mag;
    end
  end

  logic [MW-1:0]    res_m1, res_m2;
  logic [PW-1:0]    res_idx;
  logic             res_sgn;
  logic [APP_W-1:0] e_buf [ROW_MAX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_m1 <= MAG_TOP; trk_m2 <= MAG_TOP; trk_idx <= '0; trk_sgn <= 1'b0;
      res_m1 <= '0; res_m2 <= '0; res_idx <= '0; res_sgn <= 1'b0;
      rec_valid <= 1'b0;
      for (int i = 0; i < ROW_MAX; i++) e_buf[i] <= '0;
    end else begin
      if (in_valid) begin
        trk_m1 <= u_m1; trk_m2 <= u_m2; trk_idx <= u_idx; trk_sgn <= u_sgn;
        if ({1'b0, in_pos} < (PW+1)'(ROW_MAX)) e_buf[in_pos] <= e_in;
      end
      if (in_close) begin
        res_m1  <= in_valid ? u_m1  : trk_m1;
        res_m2  <= in_valid ? u_m2  : trk_m2;
        res_idx <= in_valid ? u_idx : trk_idx;
        res_sgn <= in_valid ? u_sgn : trk_sgn;
        rec_valid <= 1'b1;
      end
    end
  end

  assign new_rec = {scl(res_m1), scl(res_m2), res_idx};

  // read-out of updated APP values
  logic [APP_W-1:0] e_rd;
  logic [MW-1:0]    n_mag;
  logic             n_neg;
  logic [XW-1:0]    e_x, n_x, sum;

  assign e_rd  = e_buf[out_pos];
  assign n_mag = scl((out_pos == res_idx) ? res_m2 : res_m1);
  assign n_neg = res_sgn ^ e_rd[APP_W-1];
  assign e_x   = {{2{e_rd[APP_W-1]}}, e_rd};
  assign n_x   = {{(XW-MW){1'b0}}, n_mag};
  assign sum   = n_neg ? e_x - n_x : e_x + n_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_app   <= '0;
      out_sign  <= 1'b0;
    end else begin
      out_valid <= out_req;
      if (out_req) begin
        out_app  <= sat_app(sum);
        out_sign <= n_neg;
      end
    end
  end

  p_min_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (res_m1 <= res_m2));

  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(trk_m1) && $stable(trk_m2) && $stable(trk_idx) && $stable(trk_sgn)));

  p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);

  p_close_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_close |=> rec_valid);

  p_rec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_close |=> $stable(new_rec));
endmodule

// File: tb/sim_nms_check_unit.sv
module sim_nms_check_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_start = 0, in_close = 0, old_sign = 0, out_req = 0;
  logic [4:0] in_pos = '0, out_pos = '0;
  logic [7:0] in_app = '0;
  logic [14:0] old_rec = '0;
  logic out_valid, out_sign, rec_valid;
  logic [7:0] out_app;
  logic [14:0] new_rec;

  always #5 clk = ~clk;

  nms_check_unit u0 (.clk, .rst_n, .in_valid, .in_start, .in_close, .in_pos, .in_app,
    .old_rec, .old_sign, .out_req, .out_pos, .out_valid, .out_app, .out_sign,
    .new_rec, .rec_valid);

  int checks = 0, errors = 0;
  int n;
  int app_a [22];
  bit osg_a [22];
  int eexp [22];
  int xm1, xm2, xidx, xsgn;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat8(input int v);
    return (v > 127) ? 127 : (v < -128) ? -128 : v;
  endfunction
  function automatic int scl(input int m);
    return m / 2 + m / 4;
  endfunction

  function automatic void model();
    int om1, om2, oidx, lm, lold, mag;
    om1 = old_rec[14:10]; om2 = old_rec[9:5]; oidx = old_rec[4:0];
    xm1 = 31; xm2 = 31; xidx = 0; xsgn = 0;
    for (int i = 0; i < n; i++) begin
      lm = (i == oidx) ? om2 : om1;
      lold = osg_a[i] ? -lm : lm;
      eexp[i] = sat8(app_a[i] - lold);
      mag = (eexp[i] < 0) ? -eexp[i] : eexp[i];
      if (mag > 31) mag = 31;
      if (eexp[i] < 0) xsgn ^= 1;
      if (mag < xm1) begin xm2 = xm1; xm1 = mag; xidx = i; end
      else if (mag < xm2) xm2 = mag;
    end
  endfunction

  function automatic int rec_exp();
    return (scl(xm1) << 10) | (scl(xm2) << 5) | xidx;
  endfunction

  // mode 0: separate close, 1: close with last entry, 2: no close
  task automatic gather(input bit gaps, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1; in_start = (i == 0); in_pos = 5'(i); in_app = 8'(app_a[i]);
      old_sign = osg_a[i]; in_close = (mode == 1) && (i == n - 1);
      if (gaps) begin
        @(negedge clk);
        in_valid = 0; in_start = $urandom_range(0, 1); in_close = 0;
        in_pos = 5'($urandom_range(0, 21)); in_app = 8'($urandom);
        old_sign = $urandom_range(0, 1);
      end
    end
    @(negedge clk);
    in_valid = 0; in_start = 0; in_close = (mode == 0);
    if (mode == 0) begin @(negedge clk); in_close = 0; end
  endtask

  task automatic close_only();
    @(negedge clk); in_close = 1;
    @(negedge clk); in_close = 0;
  endtask

  task automatic check_rec(input string req);
    chk(rec_valid === 1'b1, req, rec_valid, 1);
    chk(new_rec === 15'(rec_exp()), req, new_rec, rec_exp());
  endtask

  task automatic emit(input string req);
    int mag, neg, exp_app;
    for (int i = 0; i < n; i++) begin
      out_req = 1; out_pos = 5'(i);
      @(negedge clk);
      mag = scl((i == xidx) ? xm2 : xm1);
      neg = xsgn ^ (eexp[i] < 0);
      exp_app = sat8(eexp[i] + (neg ? -mag : mag));
      chk(out_valid === 1'b1, req, out_valid, 1);
      chk($signed(out_app) == exp_app, req, $signed(out_app), exp_app);
      chk(out_sign === neg[0], "R4", out_sign, neg);
    end
    out_req = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(out_valid === 1'b0, "R8", out_valid, 0);
    chk(rec_valid === 1'b0, "R8", rec_valid, 0);
    chk(out_app === 8'd0, "R8", out_app, 0);
    chk(out_sign === 1'b0, "R8", out_sign, 0);
    chk(new_rec === 15'd0, "R8", new_rec, 0);
  endtask

  task automatic t_basic();
    int v [6] = '{7, -3, 12, -20, 5, 9};
    n = 6; old_rec = '0;
    for (int i = 0; i < n; i++) begin app_a[i] = v[i]; osg_a[i] = 0; end
    model(); gather(0, 0); check_rec("R3"); emit("R5");
  endtask

  task automatic t_rebuild();
    int v [8] = '{30, -12, 4, 18, -7, 25, -40, 11};
    n = 8; old_rec = {5'd4, 5'd9, 5'd2};
    for (int i = 0; i < n; i++) begin app_a[i] = v[i]; osg_a[i] = (i % 3 == 1); end
    model(); gather(0, 1); check_rec("R1"); emit("R1");
  endtask

  task automatic t_saturate();
    n = 3; old_rec = {5'd20, 5'd25, 5'd1};
    app_a[0] = 120;  osg_a[0] = 1;
    app_a[1] = -120; osg_a[1] = 0;
    app_a[2] = 5;    osg_a[2] = 0;
    model();
    chk(eexp[0] == 127 && eexp[1] == -128, "R1", eexp[0], 127);
    gather(0, 0); check_rec("R2"); emit("R5");
  endtask

  task automatic t_ties();
    int v [4] = '{10, -10, 10, 20};
    n = 4; old_rec = '0;
    for (int i = 0; i < n; i++) begin app_a[i] = v[i]; osg_a[i] = 0; end
    model(); gather(0, 0);
    chk(new_rec[4:0] === 5'd0, "R2", new_rec[4:0], 0);
    chk(new_rec[14:10] === new_rec[9:5], "R2", new_rec[9:5], new_rec[14:10]);
    check_rec("R2"); emit("R4");
  endtask

  task automatic t_gaps();
    int v [6] = '{-9, 14, 3, -27, 6, -2};
    n = 6; old_rec = {5'd3, 5'd6, 5'd4};
    for (int i = 0; i < n; i++) begin app_a[i] = v[i]; osg_a[i] = (i % 2 == 0); end
    model(); gather(1, 0); check_rec("R6"); emit("R6");
  endtask

  task automatic t_full_row();
    n = 22; old_rec = {5'd2, 5'd5, 5'd21};
    for (int i = 0; i < n; i++) begin app_a[i] = i * 7 - 70; osg_a[i] = (i % 4 == 3); end
    model(); gather(0, 1); check_rec("R2"); emit("R5");
  endtask

  task automatic t_two_layers();
    int reca;
    n = 4; old_rec = '0;
    app_a[0] = 2; app_a[1] = -1; app_a[2] = 6; app_a[3] = 3;
    for (int i = 0; i < n; i++) osg_a[i] = 0;
    model(); gather(0, 0); reca = rec_exp(); check_rec("R7");
    app_a[0] = 40; app_a[1] = -17; app_a[2] = 22; app_a[3] = 19;
    model(); gather(1, 2);
    chk(new_rec === 15'(reca), "R7", new_rec, reca);
    close_only(); check_rec("R7"); emit("R7");
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_rebuild();
    t_saturate();
    t_ties();
    t_gaps();
    t_full_row();
    t_two_layers();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule